// File: doc/BRIEF.md
# Pixel Hit Latch with Token Readout

This block is the digital part of a single cell in a sparsified pixel matrix. While the acquisition window is open, the cell watches its discriminator. The first pulse it sees sets a hit flag. In the same clock edge, the cell's local time-stamp register stops following the shared time-stamp counter. From then on it holds the counter value that was present at the moment of the hit. Every pulse after that is ignored until the cell is read out or reset.

Readout uses a token that passes along a daisy chain of cells. A cell with no hit passes the token on combinationally, so empty cells cost no readout cycles. A cell with a hit keeps the token for exactly one clock. During that clock it raises its row and column get lines and drives its frozen time stamp onto the column bus, with an output-enable beside the data. On the next readout clock edge it clears its hit, and the token then continues down the chain. The analog front end and the matrix-level serializer are not part of this block.

Top module: `pixel_token_cell`

## Requirements
- R1: While rst_n is low, and after it is released, the cell holds no hit: get_x, get_y and ts_oe are 0, ts_bus is 0, and tok_out equals tok_in.
- R2: A disc_hit of 1 sampled at a rising clock edge while acq_en is 1 sets the hit. A later readout then shows the hit as get_x = get_y = ts_oe = 1 while tok_in is 1.
- R3: The time stamp read out equals the ts_count value sampled at the same clock edge that set the hit, even if ts_count keeps changing afterwards.
- R4: Once a hit is held, further disc_hit pulses change neither the hit nor the stored time stamp until readout or reset.
- R5: A disc_hit sampled while acq_en is 0 does not set a hit.
- R6: A cell holding no hit drives tok_out equal to tok_in in the same cycle, with no clock edge in between.
- R7: A cell holding a hit that sees tok_in = 1 drives tok_out = 0, get_x = get_y = ts_oe = 1, and ts_bus equal to its stored time stamp.
- R8: One clock edge after R7 applies, the hit is cleared: ts_oe, get_x and get_y return to 0 and tok_out follows tok_in. A token that stays high afterwards finds an empty cell.
- R9: Whenever ts_oe is 0, ts_bus is 0, including while a hit is held with tok_in = 0.
- R10: Pulling rst_n low while a hit is held clears that hit, so a later readout finds the cell empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Master reset, asynchronous, active low |
| acq_en | input | 1 | Acquisition window open |
| disc_hit | input | 1 | Discriminator output |
| ts_count | input | TS_W (5) | Shared time-stamp counter |
| tok_in | input | 1 | Token from the previous cell |
| tok_out | output | 1 | Token to the next cell |
| get_x | output | 1 | Column get line |
| get_y | output | 1 | Row get line |
| ts_oe | output | 1 | Column bus output enable |
| ts_bus | output | TS_W (5) | Time stamp driven onto the column bus, 0 when not enabled |

## Verification
The hit and its time stamp appear one clock edge after the pulse is sampled. The bench therefore updates its model with the inputs it drives at a falling edge, and compares against outputs only after the following rising edge. Token pass-through, the get lines and the bus are combinational in tok_in, so they are sampled 1 ns after tok_in changes, within the same cycle. The release of the token (R8) is checked at the next falling edge, one rising edge after ownership began.

// File: rtl/pixel_cell_pkg.sv
package pixel_cell_pkg;

  // Hit flag update: readout clear has priority, then a gated pulse sets it.
  function automatic logic hit_next(input logic held, input logic window,
                                    input logic pulse, input logic read_done);
    if (read_done)      return 1'b0;
    else if (held)      return 1'b1;
    else                return window & pulse;
  endfunction

  // Token passes through only a cell with nothing to report.
  function automatic logic token_pass(input logic tin, input logic held);
    return tin & ~held;
  endfunction

endpackage

// File: rtl/pcell_hit_latch.sv
module pcell_hit_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic acq_en,
  input  logic disc_hit,
  input  logic read_done,
  output logic hit_q,
  output logic hit_set
);
  import pixel_cell_pkg::*;

  assign hit_set = ~hit_q & acq_en & disc_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= 1'b0;
    else        hit_q <= hit_next(hit_q, acq_en, disc_hit, read_done);
  end
endmodule

// File: rtl/pcell_ts_reg.sv
module pcell_ts_reg #(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hit_q,
  input  logic [TS_W-1:0] ts_count,
  output logic [TS_W-1:0] ts_q
);
  // Tracks the counter while empty; the edge that sets the hit loads the last value.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ts_q <= '0;
    else if (!hit_q) ts_q <= ts_count;
  end
endmodule

// File: rtl/pcell_token_core.sv
module pcell_token_core #(
  parameter int TS_W = 5
) (
  input  logic            tok_in,
  input  logic            hit_q,
  input  logic [TS_W-1:0] ts_q,
  output logic            tok_out,
  output logic            owns,
  output logic [TS_W-1:0] bus_data
);
  import pixel_cell_pkg::*;

  always_comb begin
    tok_out  = token_pass(tok_in, hit_q);
    owns     = tok_in & hit_q;
    bus_data = owns ? ts_q : '0;
  end
endmodule

// File: rtl/pixel_token_cell.sv
module pixel_token_cell #(
  parameter int TS_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            acq_en,
  input  logic            disc_hit,
  input  logic [TS_W-1:0] ts_count,
  input  logic            tok_in,
  output logic            tok_out,
  output logic            get_x,
  output logic            get_y,
  output logic            ts_oe,
  output logic [TS_W-1:0] ts_bus
);
  // Named internal events, visible to the bound checker.
  logic            hit_q;
  logic            hit_set;
  logic            read_done;
  logic [TS_W-1:0] ts_q;

  pcell_hit_latch u_hit (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .disc_hit(disc_hit),
    .read_done(read_done), .hit_q(hit_q), .hit_set(hit_set)
  );

  pcell_ts_reg #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .hit_q(hit_q), .ts_count(ts_count), .ts_q(ts_q)
  );

  pcell_token_core #(.TS_W(TS_W)) u_tok (
    .tok_in(tok_in), .hit_q(hit_q), .ts_q(ts_q),
    .tok_out(tok_out), .owns(read_done), .bus_data(ts_bus)
  );

  assign get_x = read_done;
  assign get_y = read_done;
  assign ts_oe = read_done;
endmodule

// File: rtl/pixel_token_cell_chk.sv
module pixel_token_cell_chk #(
  parameter int TS_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acq_en,
  input logic            tok_in,
  input logic            tok_out,
  input logic            get_x,
  input logic            get_y,
  input logic            ts_oe,
  input logic [TS_W-1:0] ts_bus,
  input logic            hit_q,
  input logic [TS_W-1:0] ts_q
);
  assert_tok_needs_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tok_out |-> tok_in);

  assert_owner_drives_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ts_oe |-> (get_x && get_y && !tok_out));

  assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ts_oe |=> (!ts_oe && !hit_q));

  assert_bus_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !ts_oe |-> (ts_bus == '0));

  assert_frozen_stamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_q && !ts_oe) |=> (hit_q && $stable(ts_q)));

  assert_closed_window_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!acq_en && !hit_q) |=> !hit_q);
endmodule

bind pixel_token_cell pixel_token_cell_chk #(.TS_W(TS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .tok_in(tok_in),
  .tok_out(tok_out), .get_x(get_x), .get_y(get_y), .ts_oe(ts_oe),
  .ts_bus(ts_bus), .hit_q(hit_q), .ts_q(ts_q)
);

// File: tb/tb_pixel_token_cell.sv
module tb_pixel_token_cell;
  localparam int TS_W = 5;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            acq_en = 1'b0;
  logic            disc_hit = 1'b0;
  logic [TS_W-1:0] ts_count = '0;
  logic            tok_in = 1'b0;
  logic            tok_out, get_x, get_y, ts_oe;
  logic [TS_W-1:0] ts_bus;

  int checks = 0;
  int failures = 0;

  logic            m_hit;
  logic [TS_W-1:0] m_ts;

  always #5 clk = ~clk;

  pixel_token_cell #(.TS_W(TS_W)) dut (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .disc_hit(disc_hit),
    .ts_count(ts_count), .tok_in(tok_in), .tok_out(tok_out),
    .get_x(get_x), .get_y(get_y), .ts_oe(ts_oe), .ts_bus(ts_bus)
  );

  // Bench restatement of the hit rule, written as a capture decision.
  function automatic logic captures(input logic held, input logic win, input logic p);
    return (!held) && win && p;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drive one cycle of inputs at a falling edge; model the next rising edge.
  task automatic drive(input logic win, input logic p, input logic [TS_W-1:0] cnt);
    @(negedge clk);
    acq_en = win; disc_hit = p; ts_count = cnt; tok_in = 1'b0;
    if (captures(m_hit, win, p)) begin
      m_hit = 1'b1;
      m_ts  = cnt;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; acq_en = 1'b0; disc_hit = 1'b0; tok_in = 1'b0;
    m_hit = 1'b0; m_ts = '0;
    #1;
    check("R1 oe in reset", ts_oe, 0);
    check("R1 tok in reset", tok_out, tok_in);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Readout of one cell, with the token held high across two edges.
  task automatic readout(input string tag);
    @(negedge clk);
    acq_en = 1'b0; disc_hit = 1'b0;
    tok_in = 1'b0;
    #1;
    check({"R9 bus idle ", tag}, {ts_oe, ts_bus}, 0);
    check({"R6 tok low ", tag}, tok_out, 0);
    tok_in = 1'b1;
    #1;
    if (m_hit) begin
      check({"R7 tok held ", tag}, tok_out, 0);
      check({"R7 gets ", tag}, {get_x, get_y, ts_oe}, 3'b111);
      check({"R3 stamp ", tag}, ts_bus, m_ts);
    end else begin
      check({"R6 pass ", tag}, tok_out, 1);
      check({"R1 R5 no gets ", tag}, {get_x, get_y, ts_oe}, 0);
    end
    @(negedge clk);
    #1;
    check({"R8 pass after ", tag}, tok_out, 1);
    check({"R8 released ", tag}, {get_x, get_y, ts_oe, ts_bus}, 0);
    m_hit = 1'b0;
    @(negedge clk);
    tok_in = 1'b0;
    #1;
    check({"R8 stays empty ", tag}, tok_out, 0);
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    m_hit = 1'b0; m_ts = '0;
    #1;
    check("R1 tok at start", tok_out, tok_in);
    check("R1 bus at start", {get_x, get_y, ts_oe, ts_bus}, 0);
    do_reset();
    @(negedge clk); #1;
    check("R1 after release", {get_x, get_y, ts_oe, ts_bus, tok_out}, 0);

    // Directed: a pulse outside the window (R5).
    drive(1'b0, 1'b1, 5'd7);
    drive(1'b0, 1'b1, 5'd8);
    readout("R5 directed");

    // Directed: first pulse wins, later pulses ignored (R2, R3, R4).
    drive(1'b1, 1'b0, 5'd1);
    drive(1'b1, 1'b1, 5'd31);
    drive(1'b1, 1'b1, 5'd4);
    drive(1'b1, 1'b0, 5'd9);
    readout("R2 R4 directed");

    // Directed: reset while holding (R10).
    drive(1'b1, 1'b1, 5'd17);
    do_reset();
    readout("R10 directed");

    // Random trials.
    for (int t = 0; t < 60; t++) begin
      int len;
      len = 4 + ($urandom % 12);
      for (int c = 0; c < len; c++)
        drive(($urandom % 4) != 0, ($urandom % 5) == 0, TS_W'($urandom));
      for (int c = 0; c < 3; c++)
        drive(1'b0, $urandom % 2, TS_W'($urandom));
      if (($urandom % 8) == 0) begin
        do_reset();
        readout("R10 random");
      end else begin
        readout("R2 R3 R4 random");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule